// File: doc/BRIEF.md
# Calibrated RTC Prescaler

This block turns a 32.768 kHz oscillator clock into a once-per-second tick and counts those seconds up to a minute boundary. Crystals drift, so a signed correction can be programmed. Once per minute, the last second before the minute boundary is stretched or shortened by twice the programmed magnitude, counted in oscillator cycles. A magnitude of zero turns the correction off.

A monitor pin can show the internal timing for trimming. It can show the 1 Hz divider, two faster divider taps, or the raw oscillator. The pin is low unless the monitor is enabled. It is also held low in battery mode and for reserved rate codes. A new calibration value is held in a shadow register and takes effect at the next minute boundary. Monitor controls take effect at once. The divider width and the number of seconds per minute are parameters, so a small configuration can be checked quickly.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, `tick_1hz`, `tick_min` and `mon_out` are low. The calibration and monitor enable are cleared. The first tick arrives 2^DIV_W cycles after reset is released.
- R2: An uncorrected second lasts exactly 2^DIV_W input cycles. `tick_1hz` is a one-cycle pulse. `tick_min` pulses together with every SECS-th `tick_1hz`, and at no other time.
- R3: With sign 0 and magnitude m > 0, the second that ends at the minute boundary lasts 2^DIV_W + 2m cycles.
- R4: With sign 1 and 2m < 2^DIV_W - 1, that second lasts 2^DIV_W - 2m cycles.
- R5: With sign 1 and 2m >= 2^DIV_W - 1, that second lasts exactly one cycle and still produces exactly one tick.
- R6: A magnitude of 0 makes no correction, whatever the sign.
- R7: A calibration write applies from the next minute boundary. The minute in progress when the write occurs still uses the old value.
- R8: With the monitor enabled, no battery mode and rate[2]=0, `mon_out` follows the prescaler count (0 at each tick, then +1 per cycle). Rate[1:0]=00 gives the count MSB, 01 gives count bit 2, and 10 gives count bit 1.
- R9: Rate[1:0]=11 passes the input clock to `mon_out` unchanged, and calibration has no effect on it.
- R10: During an add-corrected second, the count holds at its all-ones value for 2m cycles. Under codes 00, 01 and 10 the monitor therefore holds its level instead of toggling.
- R11: `mon_out` is low whenever the monitor enable is 0, `batt_mode` is 1, or rate[2] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_we | input | 1 | Write strobe for the calibration shadow register |
| cal_mag_in | input | 8 | Calibration magnitude, in units of two cycles |
| cal_neg_in | input | 1 | Calibration sign: 1 removes cycles, 0 adds cycles |
| ctl_we | input | 1 | Write strobe for the monitor controls |
| ctl_oe_in | input | 1 | Monitor enable |
| ctl_rate_in | input | 3 | Monitor rate select |
| batt_mode | input | 1 | Battery mode: forces the monitor low |
| mon_out | output | 1 | Monitor output |
| tick_1hz | output | 1 | One-cycle pulse at the end of each second |
| tick_min | output | 1 | One-cycle pulse at the end of each minute |

## Verification
The hardest case to reach is a subtraction larger than the whole second. The counter must then wrap on its very first cycle, and the same edge that wraps it also closes the minute. The bench reaches this, and every other corrected second, by writing each calibration value right after a minute tick. It then measures two full minutes, the first showing the old value and the second the new one. During both minutes it checks every monitor sample against a count computed from the cycles since the last tick. This includes the held level while an add correction is running.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 15,
  parameter int SECS  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_we,
  input  logic [7:0] cal_mag_in,
  input  logic       cal_neg_in,
  input  logic       ctl_we,
  input  logic       ctl_oe_in,
  input  logic [2:0] ctl_rate_in,
  input  logic       batt_mode,
  output logic       mon_out,
  output logic       tick_1hz,
  output logic       tick_min
);
  localparam int EW = (DIV_W > 9) ? DIV_W + 1 : 10;
  localparam int SW = (SECS > 1) ? $clog2(SECS) : 1;
  localparam logic [DIV_W-1:0] CMAX = '1;
  localparam logic [EW-1:0] TOP = {{(EW-DIV_W){1'b0}}, CMAX};
  localparam logic [SW-1:0] SLAST = SW'(SECS - 1);

  logic [DIV_W-1:0] cnt;
  logic [SW-1:0]    sec;
  logic [8:0]       ext;
  logic             stl;
  logic [7:0]       shd_mag, act_mag;
  logic             shd_neg, act_neg;
  logic             oe;
  logic [2:0]       rate;

  logic [8:0]    dbl;
  logic [EW-1:0] dbl_w, cnt_w, sub_term;
  logic          last_sec, c_add, c_sub, start_stall, wrap, sel;

  assign dbl      = {act_mag, 1'b0};
  assign dbl_w    = {{(EW-9){1'b0}}, dbl};
  assign cnt_w    = {{(EW-DIV_W){1'b0}}, cnt};
  assign last_sec = (sec == SLAST);
  assign c_add    = last_sec && (act_mag != 8'd0) && !act_neg;
  assign c_sub    = last_sec && (act_mag != 8'd0) && act_neg;
  assign sub_term = (dbl_w >= TOP) ? '0 : TOP - dbl_w;
  assign start_stall = c_add && !stl && (cnt == CMAX);
  assign wrap = c_sub ? (cnt_w >= sub_term)
              : stl   ? (ext == 9'd0)
              : ((cnt == CMAX) && !c_add);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sec <= '0; ext <= '0; stl <= 1'b0;
      act_mag <= '0; act_neg <= 1'b0;
      tick_1hz <= 1'b0; tick_min <= 1'b0;
    end else begin
      tick_1hz <= wrap;
      tick_min <= wrap && last_sec;
      if (wrap) begin
        cnt <= '0;
        stl <= 1'b0;
        if (last_sec) begin
          sec     <= '0;
          act_mag <= shd_mag;
          act_neg <= shd_neg;
        end else begin
          sec <= sec + 1'b1;
        end
      end else if (start_stall) begin
        stl <= 1'b1;
        ext <= dbl - 9'd1;
      end else if (stl) begin
        ext <= ext - 9'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_mag <= '0; shd_neg <= 1'b0; oe <= 1'b0; rate <= '0;
    end else begin
      if (cal_we) begin
        shd_mag <= cal_mag_in;
        shd_neg <= cal_neg_in;
      end
      if (ctl_we) begin
        oe   <= ctl_oe_in;
        rate <= ctl_rate_in;
      end
    end
  end

  always_comb begin
    case (rate[1:0])
      2'b00:   sel = cnt[DIV_W-1];
      2'b01:   sel = cnt[2];
      2'b10:   sel = cnt[1];
      default: sel = clk;
    endcase
  end

  assign mon_out = oe && !batt_mode && !rate[2] && sel;

  AST_MIN_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    tick_min |-> tick_1hz); // R2
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= SLAST); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stl |=> (cnt == CMAX) || tick_1hz); // R10
  AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stl |-> (ext < dbl)); // R3
  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_min |-> $stable(act_mag) && $stable(act_neg)); // R7
  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_mode || !oe) |-> !mon_out); // R11
endmodule

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
  localparam int DW = 6;
  localparam int NS = 4;
  localparam int BASE = 1 << DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_we = 1'b0, cal_neg_in = 1'b0, ctl_we = 1'b0, ctl_oe_in = 1'b0, batt_mode = 1'b0;
  logic [7:0] cal_mag_in = '0;
  logic [2:0] ctl_rate_in = '0;
  logic mon_out, tick_1hz, tick_min;

  int errors = 0;
  int checks = 0;
  int cur_oe = 0, cur_batt = 0, cur_rate = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_prescaler #(.DIV_W(DW), .SECS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .cal_we(cal_we), .cal_mag_in(cal_mag_in),
    .cal_neg_in(cal_neg_in), .ctl_we(ctl_we), .ctl_oe_in(ctl_oe_in),
    .ctl_rate_in(ctl_rate_in), .batt_mode(batt_mode),
    .mon_out(mon_out), .tick_1hz(tick_1hz), .tick_min(tick_min));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic int exp_mon(input int k);
    int c;
    if (cur_oe == 0 || cur_batt != 0 || cur_rate > 3) return 0;
    c = (k > BASE - 1) ? BASE - 1 : k;
    case (cur_rate)
      0: return (c >> (DW - 1)) & 1;
      1: return (c >> 2) & 1;
      2: return (c >> 1) & 1;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_len(input int m, input int neg);
    if (m == 0) return BASE;
    if (neg != 0) return (2 * m >= BASE - 1) ? 1 : BASE - 2 * m;
    return BASE + 2 * m;
  endfunction

  task automatic run_sec(output int len, output bit mn, output int bad);
    int k;
    len = 0; bad = 0;
    do begin
      step();
      cal_we = 1'b0; ctl_we = 1'b0;
      len++;
      k = tick_1hz ? 0 : len;
      if (exp_mon(k) != int'(mon_out)) bad++;
    end while (!tick_1hz && len < 2000);
    mn = tick_min;
  endtask

  task automatic run_min(input int last_len, input string lreq,
                         input string mreq, input string mreq_last);
    int len, bad;
    bit mn;
    for (int s = 0; s < NS; s++) begin
      run_sec(len, mn, bad);
      if (s < NS - 1) begin
        chk(len == BASE && !mn, "R2 second length", len, BASE);
        chk(bad == 0, mreq, bad, 0);
      end else begin
        chk(len == last_len, lreq, len, last_len);
        chk(mn, "R2 minute tick", mn, 1);
        chk(bad == 0, mreq_last, bad, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int mags[11] = '{0, 0, 1, 3, 100, 1, 5, 31, 32, 255, 255};
    int negs[11] = '{0, 1, 0, 0, 0,   1, 1, 1,  1,  1,   0};
    int prev_len, prev_add, nl, add, len, bad;
    bit mn;
    string lab;
    repeat (3) step();
    chk(!tick_1hz && !tick_min, "R1 ticks in reset", tick_1hz, 0);
    chk(!mon_out, "R1 monitor in reset", mon_out, 0);
    rst_n = 1'b1;
    run_sec(len, mn, bad);
    chk(len == BASE, "R1 first second", len, BASE);
    chk(!mn, "R1 no minute tick", mn, 0);
    for (int s = 1; s < NS; s++) begin
      run_sec(len, mn, bad);
      chk(len == BASE, "R2 second length", len, BASE);
      chk(mn == (s == NS - 1), "R2 minute tick placement", mn, s == NS - 1);
    end
    prev_len = BASE; prev_add = 0;
    for (int i = 0; i < 11; i++) begin
      cal_mag_in = 8'(mags[i]); cal_neg_in = negs[i][0]; cal_we = 1'b1;
      ctl_oe_in = 1'b1; ctl_rate_in = 3'(i % 3); ctl_we = 1'b1;
      cur_oe = 1; cur_rate = i % 3;
      run_min(prev_len, "R7 old value kept", "R8 monitor", prev_add != 0 ? "R10 monitor stall" : "R8 monitor");
      nl = exp_len(mags[i], negs[i]);
      add = (mags[i] != 0 && negs[i] == 0) ? 1 : 0;
      if (mags[i] == 0) lab = "R6 zero magnitude";
      else if (negs[i] != 0 && 2 * mags[i] >= BASE - 1) lab = "R5 oversized subtract";
      else if (negs[i] != 0) lab = "R4 subtract";
      else lab = "R3 add";
      run_min(nl, lab, "R8 monitor", add != 0 ? "R10 monitor stall" : "R8 monitor");
      prev_len = nl; prev_add = add;
    end
    ctl_oe_in = 1'b1; ctl_rate_in = 3'd3; ctl_we = 1'b1; cur_oe = 1; cur_rate = 3;
    run_min(prev_len, "R3 add", "R9 passthrough", "R9 passthrough under calibration");
    @(negedge clk); #1;
    chk(!mon_out, "R9 passthrough low phase", mon_out, 0);
    ctl_rate_in = 3'd1; ctl_we = 1'b1; cur_rate = 1; batt_mode = 1'b1; cur_batt = 1;
    run_min(prev_len, "R3 add", "R11 battery gate", "R11 battery gate");
    batt_mode = 1'b0; cur_batt = 0; ctl_oe_in = 1'b0; ctl_we = 1'b1; cur_oe = 0;
    run_min(prev_len, "R3 add", "R11 enable gate", "R11 enable gate");
    ctl_oe_in = 1'b1; ctl_rate_in = 3'd5; ctl_we = 1'b1; cur_oe = 1; cur_rate = 5;
    run_min(prev_len, "R3 add", "R11 reserved rate", "R11 reserved rate");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule